// File: doc/BRIEF.md
# Page Load Buffer with Idle Timeout

This block is the word-load front end of a page-programmed non-volatile memory. A host presents write strobes, each carrying a 16-bit word address and a 16-bit data word. The low address bits select a slot within a page and the upper bits select the page. The first write opens a load window and latches its page. Later writes to that page land in their slots in any order. A per-slot valid bitmap records which slots the window has filled.

The window stays open for as long as writes keep arriving within a configurable number of clock cycles of each other. When that idle limit runs out, the block raises `busy` and runs a program cycle of fixed length. During that cycle it copies the whole page into a register-file array model. Every slot that was not written in the window is stored as all-ones. A registered read port returns array contents. A write to another page while a window is open is discarded and sets a sticky error flag.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset, `busy` and `page_err` are both 0.
- R2: A word written at address A is stored in page A[15:7] at slot A[6:0]. After the commit, a read of A returns it. The read port has one cycle of latency. The array model keeps the low ARR_PAGE_BITS bits of the page number, so pages alias modulo 2^ARR_PAGE_BITS.
- R3: Words of one window may be written in any slot order, with the same committed result.
- R4: While a window is open, a write whose A[15:7] differs from the latched page leaves the array unchanged and sets `page_err`. The flag stays at 1 until reset.
- R5: A write that arrives LOAD_TIMEOUT or fewer clock edges after the previous accepted write extends the same window. `busy` stays 0 and the word joins that page's commit.
- R6: After LOAD_TIMEOUT consecutive clock edges with no accepted write, `busy` is 1 at the next sample and stays high for exactly PROG_CYCLES cycles.
- R7: Every slot of the page that the window did not write is committed as 16'hFFFF.
- R8: Writing the same slot twice in one window commits the later data.
- R9: Writes presented while `busy` is 1 are dropped. They neither change the array nor open a new window.
- R10: The valid bitmap is cleared when a window opens. Slots written only in an earlier window on the same page are committed as 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 16 | Write address: page in [15:7], slot in [6:0] |
| wr_data | input | 16 | Write data |
| rd_addr | input | 16 | Array read address |
| rd_data | output | 16 | Registered array read data |
| busy | output | 1 | Program cycle in progress |
| page_err | output | 1 | Sticky flag for a write to the wrong page |

## Verification
The assertions assume that `wr_en` never carries a write during reset and that PROG_CYCLES is at least one more than the page size. Only then can the commit copy finish inside the busy interval. The stimulus drives every input on the falling edge and releases `wr_en` on the very sample where `busy` is seen low. This way the drop test never opens a stray window. The idle-gap check in the checker counts from accepted writes only, so rejected page writes are placed before a fresh accepted write.

// File: rtl/plb_pkg.sv
package plb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } plb_state_e;
endpackage

// File: rtl/plb_cycle_ctr.sv
module plb_cycle_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/plb_page_buf.sv
module plb_page_buf #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] q,
  output logic              qv
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  valid;

  // data storage: plain synchronous write / synchronous read
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    q <= mem[ridx];
  end

  // slot bitmap: a new window wipes everything but its first slot
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= '0;
      qv    <= 1'b0;
    end else begin
      if (start)   valid <= DEPTH'(1) << widx;
      else if (we) valid[widx] <= 1'b1;
      qv <= valid[ridx];
    end
  end
endmodule

// File: rtl/plb_array.sv
module plb_array #(
  parameter int DATA_W = 16,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int WORD_BITS     = 7,
  parameter int ARR_PAGE_BITS = 2,
  parameter int LOAD_TIMEOUT  = 16,
  parameter int PROG_CYCLES   = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              page_err
);
  import plb_pkg::*;

  localparam int PAGE_WORDS = 1 << WORD_BITS;
  localparam int PAGE_W     = ADDR_W - WORD_BITS;
  localparam int PROG_LEN   = (PROG_CYCLES > PAGE_WORDS) ? PROG_CYCLES : PAGE_WORDS + 1;
  localparam int LT_W       = $clog2(LOAD_TIMEOUT + 1);
  localparam int PC_W       = $clog2(PROG_LEN + 1);
  localparam int ARR_AW     = ARR_PAGE_BITS + WORD_BITS;

  plb_state_e state;
  logic [PAGE_W-1:0]    page_q;
  logic [PAGE_W-1:0]    wr_page;
  logic [WORD_BITS-1:0] wr_slot;
  logic                 start, accept, mismatch, close, done;
  logic [LT_W-1:0]      tcnt;
  logic [PC_W-1:0]      pcnt;
  logic [DATA_W-1:0]    buf_q;
  logic                 buf_qv;
  logic                 cp_pend;
  logic [WORD_BITS-1:0] cp_idx;
  logic                 err_q;

  assign wr_page  = wr_addr[ADDR_W-1:WORD_BITS];
  assign wr_slot  = wr_addr[WORD_BITS-1:0];
  assign start    = wr_en && (state == ST_IDLE);
  assign accept   = start || (wr_en && (state == ST_LOAD) && (wr_page == page_q));
  assign mismatch = wr_en && (state == ST_LOAD) && (wr_page != page_q);
  assign close    = (state == ST_LOAD) && !accept && (tcnt == LT_W'(LOAD_TIMEOUT - 1));
  assign done     = (state == ST_PROG) && (pcnt == PC_W'(PROG_LEN - 1));

  // idle gap since the last accepted word
  plb_cycle_ctr #(.W(LT_W)) u_idle_ctr (
    .clk(clk), .rst(rst), .clr(accept), .en(state == ST_LOAD), .cnt(tcnt)
  );

  // program cycle length
  plb_cycle_ctr #(.W(PC_W)) u_prog_ctr (
    .clk(clk), .rst(rst), .clr(close), .en(state == ST_PROG), .cnt(pcnt)
  );

  plb_page_buf #(.DATA_W(DATA_W), .IDX_W(WORD_BITS)) u_buf (
    .clk(clk), .rst(rst), .start(start), .we(accept),
    .widx(wr_slot), .wdata(wr_data),
    .ridx(pcnt[WORD_BITS-1:0]), .q(buf_q), .qv(buf_qv)
  );

  plb_array #(.DATA_W(DATA_W), .AW(ARR_AW)) u_arr (
    .clk(clk), .we(cp_pend),
    .waddr({page_q[ARR_PAGE_BITS-1:0], cp_idx}),
    .wdata(buf_qv ? buf_q : {DATA_W{1'b1}}),
    .raddr(rd_addr[ARR_AW-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      page_q  <= '0;
      err_q   <= 1'b0;
      cp_pend <= 1'b0;
      cp_idx  <= '0;
    end else begin
      if (start)    page_q <= wr_page;
      if (mismatch) err_q  <= 1'b1;
      cp_pend <= (state == ST_PROG) && (pcnt < PC_W'(PAGE_WORDS));
      cp_idx  <= pcnt[WORD_BITS-1:0];
      case (state)
        ST_IDLE: if (start) state <= ST_LOAD;
        ST_LOAD: if (close) state <= ST_PROG;
        ST_PROG: if (done)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state == ST_PROG);
  assign page_err = err_q;
endmodule

// File: rtl/plb_checker.sv
module plb_checker #(
  parameter int LOAD_TIMEOUT = 16,
  parameter int PROG_LEN     = 200
) (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic busy,
  input logic page_err,
  input logic wr_acc
);
  int busy_len;
  int gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_len <= 0;
      gap      <= 0;
    end else begin
      busy_len <= busy ? busy_len + 1 : 0;
      if (wr_acc)                    gap <= 0;
      else if (gap < LOAD_TIMEOUT+2) gap <= gap + 1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !page_err));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    page_err |=> page_err);

  p_err_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(page_err) |-> $past(wr_en));

  p_close_gap_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (gap == LOAD_TIMEOUT));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == PROG_LEN));

  p_drop_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wr_acc);
endmodule

bind page_load_ctrl plb_checker #(
  .LOAD_TIMEOUT(LOAD_TIMEOUT),
  .PROG_LEN(PROG_LEN)
) u_plb_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy),
  .page_err(page_err), .wr_acc(accept)
);

// File: tb/page_load_ctrl_bench.sv
module page_load_ctrl_bench;
  localparam int T = 16;
  localparam int P = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy, page_err;

  int checks = 0;
  int errors = 0;
  logic [15:0] expb [128];
  logic [15:0] keep2_9;

  always #4 clk = ~clk;

  page_load_ctrl #(.LOAD_TIMEOUT(T), .PROG_CYCLES(P)) u_page_load_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .page_err(page_err)
  );

  function automatic logic [15:0] dval(int slot, int tag);
    return 16'((slot * 37 + tag * 1009 + 5) & 16'h7fff);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int page, int slot, logic [15:0] d);
    wr_en = 1'b1; wr_addr = 16'((page << 7) | slot); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // close window, check timing; optionally push writes while busy
  task automatic close_window(bit drop, int dpage, int dslot);
    int n;
    idle(T - 1);
    check("R5 busy low before timeout", 32'(busy), 32'd0);
    idle(1);
    check("R6 busy after timeout", 32'(busy), 32'd1);
    n = 0;
    while (busy) begin
      if (drop) begin
        wr_en = 1'b1; wr_addr = 16'((dpage << 7) | dslot); wr_data = 16'h1234;
      end
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R6 busy length", 32'(n), 32'(P));
  endtask

  task automatic read_word(int page, int slot, output logic [15:0] d);
    rd_addr = 16'((page << 7) | slot);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_page(string req, int page);
    logic [15:0] d;
    int bad;
    bad = 0;
    for (int i = 0; i < 128; i++) begin
      read_word(page, i, d);
      checks++;
      if (d !== expb[i]) begin
        errors++; bad++;
        if (bad < 4) $display("FAIL %s page %0d slot %0d actual=%h expected=%h",
                              req, page, i, d, expb[i]);
      end
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 page_err after reset", 32'(page_err), 32'd0);

    // R2: full page, ascending
    for (int i = 0; i < 128; i++) begin wr(1, i, dval(i, 1)); expb[i] = dval(i, 1); end
    close_window(1'b0, 0, 0);
    check_page("R2 ascending full page", 1);

    // R3: full page, descending
    for (int i = 127; i >= 0; i--) begin wr(2, i, dval(i, 2)); expb[i] = dval(i, 2); end
    close_window(1'b0, 0, 0);
    check_page("R3 descending full page", 2);
    keep2_9 = dval(9, 2);

    // R7 + R3: scattered subset, rest all-ones
    for (int i = 0; i < 128; i++) expb[i] = 16'hFFFF;
    for (int i = 0; i < 43; i++) begin
      wr(3, (i * 45) % 128, dval((i * 45) % 128, 3));
      expb[(i * 45) % 128] = dval((i * 45) % 128, 3);
    end
    close_window(1'b0, 0, 0);
    check_page("R7 scattered subset", 3);

    // R10, R4, R5, R8 on page 1 again
    for (int i = 0; i < 128; i++) expb[i] = 16'hFFFF;
    for (int i = 0; i < 5; i++) begin wr(1, i, dval(i, 4)); expb[i] = dval(i, 4); end
    check("R4 no error yet", 32'(page_err), 32'd0);
    wr(2, 9, 16'hAAAA);
    check("R4 error on wrong page", 32'(page_err), 32'd1);
    wr(1, 5, dval(5, 4)); expb[5] = dval(5, 4);
    idle(T - 1);
    check("R5 window still open", 32'(busy), 32'd0);
    wr(1, 6, dval(6, 4)); expb[6] = dval(6, 4);
    wr(1, 4, 16'h0BEE); expb[4] = 16'h0BEE;
    for (int i = 7; i < 10; i++) begin wr(1, i, dval(i, 4)); expb[i] = dval(i, 4); end
    close_window(1'b0, 0, 0);
    check_page("R10 R8 R5 reloaded page", 1);
    read_word(2, 9, d);
    check("R4 wrong-page write ignored", 32'(d), 32'(keep2_9));

    // R9: writes during busy dropped
    for (int i = 0; i < 128; i++) expb[i] = 16'hFFFF;
    wr(3, 7, dval(7, 5)); expb[7] = dval(7, 5);
    close_window(1'b1, 3, 100);
    idle(T + 3);
    check("R9 no window from dropped writes", 32'(busy), 32'd0);
    check_page("R9 dropped writes absent", 3);
    check("R4 error sticky", 32'(page_err), 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule